// File: doc/BRIEF.md
# Scheduled Multiply-Subtract-Add Unit

This block evaluates X = A*B - C*D + F on five signed two's-complement operands and returns the exact result. It is built for datapath designers who want the same expression with a different balance of hardware and latency. A synthesis-time parameter sets how many multipliers are built and how the work is spread over clock cycles. The serial form reuses one multiplier over three short cycles. The paired form runs two multipliers in parallel and finishes in two cycles. The flat form computes everything between two register stages in one long cycle.

A request is issued by raising `start_i` for one clock while the unit is idle. The unit copies the operands into its own registers on that edge, so the caller may change the operand pins at once. While the unit is working, `busy_o` is high and any further start is dropped. When the result is ready, `done_o` pulses for one cycle, and `x_o` keeps that value until the next result replaces it. Only one request is in flight at a time.

Top module: `mul_sub_add_unit`

## Requirements
- R1: `x_o` equals A*B - C*D + F, with all five operands read as signed two's complement, and is exact over the whole operand range. With the default 8-bit operands the result is 18 bits wide.
- R2: With `SCHED` = 0 (one shared multiplier), `done_o` is high in the clock cycle that begins 3 rising edges after the edge where the start was accepted.
- R3: With `SCHED` = 1 (two multipliers), `done_o` is high in the cycle that begins 2 rising edges after the accepting edge.
- R4: With `SCHED` = 2 (combinational form), `done_o` is high in the cycle that begins 1 rising edge after the accepting edge.
- R5: A start is accepted only on an edge where `busy_o` is low. `busy_o` is high from the accepting edge until the edge that raises `done_o`. A start seen while `busy_o` is high has no effect on the result, on its timing, or on later outputs.
- R6: `done_o` is high for exactly one cycle per accepted request.
- R7: `x_o` changes only on the edge that raises `done_o`. It holds its value until the next completion, whatever happens on the operand pins after the accepting edge.
- R8: While `rst_n` is low, `done_o`, `busy_o` and `x_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| a_i | input | OP_W | Signed operand A |
| b_i | input | OP_W | Signed operand B |
| c_i | input | OP_W | Signed operand C |
| d_i | input | OP_W | Signed operand D |
| f_i | input | OP_W | Signed operand F |
| busy_o | output | 1 | High while a request is being evaluated |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| x_o | output | 2*OP_W+2 | Signed result, held between completions |

## Verification
A wrong schedule step is visible at the ports: the result appears with the wrong multiplier pairing, a missing subtraction, or a lost F term. That error appears on the first `done_o` pulse, which comes one to three cycles after the start. A stuck or miscounted step counter makes `done_o` arrive early, late or twice, or leaves `busy_o` high. The bench sees this within four cycles of the start. A start that leaks through while busy either changes the captured operands, which corrupts that same result, or produces an extra done pulse one cycle after the expected one.

// File: rtl/msa_pkg.sv
package msa_pkg;

   localparam int SCHED_ONE_MUL = 0;
   localparam int SCHED_TWO_MUL = 1;
   localparam int SCHED_FLAT    = 2;

   localparam int STEP_W  = 2;
   localparam int N_OPS   = 5;

   localparam int OP_IDX_A = 0;
   localparam int OP_IDX_B = 1;
   localparam int OP_IDX_C = 2;
   localparam int OP_IDX_D = 3;
   localparam int OP_IDX_F = 4;

   function automatic int lat_of(input int sched);
      case (sched)
         SCHED_ONE_MUL: return 3;
         SCHED_TWO_MUL: return 2;
         default:       return 1;
      endcase
   endfunction

   function automatic int res_w_of(input int op_w);
      return 2 * op_w + 2;
   endfunction

endpackage

// File: rtl/msa_smul.sv
module msa_smul #(
   parameter int W = 8
) (
   input  logic signed [W-1:0]   a,
   input  logic signed [W-1:0]   b,
   output logic signed [2*W-1:0] p
);
   assign p = a * b;
endmodule

// File: rtl/msa_ctrl.sv
module msa_ctrl
   import msa_pkg::*;
#(
   parameter int LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              finish,
   output logic [STEP_W-1:0] step,
   output logic              done
);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LAT - 1);

   logic accept;

   assign accept = start && !busy;
   assign finish = busy && (step == LAST_STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         done <= 1'b0;
      end else begin
         done <= finish;
         if (accept) begin
            busy <= 1'b1;
            step <= '0;
         end else if (finish) begin
            busy <= 1'b0;
            step <= '0;
         end else if (busy) begin
            step <= step + STEP_W'(1);
         end
      end
   end
endmodule

// File: rtl/msa_opreg.sv
module msa_opreg #(
   parameter int W = 8,
   parameter int N = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [N-1:0][W-1:0] d,
   output logic [N-1:0][W-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_op
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[i] <= '0;
         else if (load)
            q[i] <= d[i];
      end
   end
endmodule

// File: rtl/msa_arith.sv
module msa_arith
   import msa_pkg::*;
#(
   parameter int OP_W  = 8,
   parameter int SCHED = SCHED_ONE_MUL,
   localparam int RES_W = 2 * OP_W + 2,
   localparam int PR_W  = 2 * OP_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    finish,
   input  logic [STEP_W-1:0]       step,
   input  logic signed [OP_W-1:0]  a,
   input  logic signed [OP_W-1:0]  b,
   input  logic signed [OP_W-1:0]  c,
   input  logic signed [OP_W-1:0]  d,
   input  logic signed [OP_W-1:0]  f,
   output logic signed [RES_W-1:0] x
);
   logic signed [RES_W-1:0] f_ext;
   assign f_ext = RES_W'(f);

   if (SCHED == SCHED_ONE_MUL) begin : g_serial
      logic signed [OP_W-1:0]  mul_l, mul_r;
      logic signed [PR_W-1:0]  prod;
      logic signed [RES_W-1:0] prod_ext, acc;

      assign mul_l    = (step == STEP_W'(0)) ? a : c;
      assign mul_r    = (step == STEP_W'(0)) ? b : d;
      assign prod_ext = RES_W'(prod);

      msa_smul #(.W(OP_W)) u_mul (.a(mul_l), .b(mul_r), .p(prod));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc <= '0;
            x   <= '0;
         end else begin
            if (run && step == STEP_W'(0)) acc <= prod_ext;
            if (run && step == STEP_W'(1)) acc <= acc - prod_ext;
            if (finish)                    x   <= acc + f_ext;
         end
      end
   end else if (SCHED == SCHED_TWO_MUL) begin : g_pair
      logic signed [PR_W-1:0]  prod_ab, prod_cd;
      logic signed [RES_W-1:0] hold_ab, hold_cd;

      msa_smul #(.W(OP_W)) u_mul_ab (.a(a), .b(b), .p(prod_ab));
      msa_smul #(.W(OP_W)) u_mul_cd (.a(c), .b(d), .p(prod_cd));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hold_ab <= '0;
            hold_cd <= '0;
            x       <= '0;
         end else begin
            if (run && step == STEP_W'(0)) begin
               hold_ab <= RES_W'(prod_ab);
               hold_cd <= RES_W'(prod_cd);
            end
            if (finish) x <= hold_ab - hold_cd + f_ext;
         end
      end
   end else begin : g_flat
      logic signed [PR_W-1:0] prod_ab, prod_cd;
      logic                   unused_ctl;

      assign unused_ctl = run ^ (^step);

      msa_smul #(.W(OP_W)) u_mul_ab (.a(a), .b(b), .p(prod_ab));
      msa_smul #(.W(OP_W)) u_mul_cd (.a(c), .b(d), .p(prod_cd));

      always_ff @(posedge clk) begin
         if (!rst_n)
            x <= '0;
         else if (finish)
            x <= RES_W'(prod_ab) - RES_W'(prod_cd) + f_ext;
      end
   end
endmodule

// File: rtl/mul_sub_add_unit.sv
module mul_sub_add_unit
   import msa_pkg::*;
#(
   parameter int OP_W  = 8,
   parameter int SCHED = SCHED_ONE_MUL,
   localparam int RES_W = 2 * OP_W + 2,
   localparam int LAT   = lat_of(SCHED)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [OP_W-1:0]  a_i,
   input  logic [OP_W-1:0]  b_i,
   input  logic [OP_W-1:0]  c_i,
   input  logic [OP_W-1:0]  d_i,
   input  logic [OP_W-1:0]  f_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [RES_W-1:0] x_o
);
   initial begin
      assert (SCHED >= SCHED_ONE_MUL && SCHED <= SCHED_FLAT)
         else $fatal(1, "mul_sub_add_unit: SCHED out of range");
      assert (OP_W >= 2)
         else $fatal(1, "mul_sub_add_unit: OP_W too small");
   end

   logic                          busy, finish, load;
   logic [STEP_W-1:0]             step;
   logic [N_OPS-1:0][OP_W-1:0]    ops_in, ops_q;
   logic signed [RES_W-1:0]       x_s;

   assign ops_in[OP_IDX_A] = a_i;
   assign ops_in[OP_IDX_B] = b_i;
   assign ops_in[OP_IDX_C] = c_i;
   assign ops_in[OP_IDX_D] = d_i;
   assign ops_in[OP_IDX_F] = f_i;
   assign load             = start_i && !busy;

   msa_ctrl #(.LAT(LAT)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_i),
      .busy   (busy),
      .finish (finish),
      .step   (step),
      .done   (done_o)
   );

   msa_opreg #(.W(OP_W), .N(N_OPS)) u_ops (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .d     (ops_in),
      .q     (ops_q)
   );

   msa_arith #(.OP_W(OP_W), .SCHED(SCHED)) u_arith (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .finish (finish),
      .step   (step),
      .a      (ops_q[OP_IDX_A]),
      .b      (ops_q[OP_IDX_B]),
      .c      (ops_q[OP_IDX_C]),
      .d      (ops_q[OP_IDX_D]),
      .f      (ops_q[OP_IDX_F]),
      .x      (x_s)
   );

   assign busy_o = busy;
   assign x_o    = x_s;
endmodule

// File: rtl/msa_chk.sv
module msa_chk
   import msa_pkg::*;
#(
   parameter int OP_W  = 8,
   parameter int SCHED = SCHED_ONE_MUL,
   localparam int RES_W = 2 * OP_W + 2,
   localparam int LAT   = lat_of(SCHED)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [OP_W-1:0]  a_i,
   input logic [OP_W-1:0]  b_i,
   input logic [OP_W-1:0]  c_i,
   input logic [OP_W-1:0]  d_i,
   input logic [OP_W-1:0]  f_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [RES_W-1:0] x_o
);
   logic                    taken;
   logic [LAT:0]            taken_hist;
   logic [OP_W-1:0]         sa, sb, sc, sd, sf;
   logic signed [RES_W-1:0] want_x;

   assign taken = start_i && !busy_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken_hist <= '0;
         sa <= '0; sb <= '0; sc <= '0; sd <= '0; sf <= '0;
      end else begin
         taken_hist <= {taken_hist[LAT-1:0], taken};
         if (taken) begin
            sa <= a_i; sb <= b_i; sc <= c_i; sd <= d_i; sf <= f_i;
         end
      end
   end

   always_comb begin
      want_x = RES_W'($signed(sa)) * RES_W'($signed(sb))
             - RES_W'($signed(sc)) * RES_W'($signed(sd))
             + RES_W'($signed(sf));
   end

   AST_RESULT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($signed(x_o) == want_x));  // R1

   if (SCHED == SCHED_ONE_MUL) begin : g_lat3
      AST_DONE_AFTER_THREE: assert property (@(posedge clk) disable iff (!rst_n)
         done_o == taken_hist[LAT]);  // R2
   end else if (SCHED == SCHED_TWO_MUL) begin : g_lat2
      AST_DONE_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
         done_o == taken_hist[LAT]);  // R3
   end else begin : g_lat1
      AST_DONE_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         done_o == taken_hist[LAT]);  // R4
   end

   AST_BUSY_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> taken_hist[0]);  // R5

   AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);  // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);  // R6

   AST_X_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(x_o));  // R7
endmodule

bind mul_sub_add_unit msa_chk #(.OP_W(OP_W), .SCHED(SCHED)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .a_i     (a_i),
   .b_i     (b_i),
   .c_i     (c_i),
   .d_i     (d_i),
   .f_i     (f_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .x_o     (x_o)
);

// File: tb/sim_mul_sub_add_unit.sv
module sim_mul_sub_add_unit;
   localparam int CLK_P = 10;
   localparam int W     = 8;
   localparam int RW    = 2 * W + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [W-1:0] a = '0, b = '0, c = '0, d = '0, f = '0;
   logic [2:0] busy, done;
   logic [2:0][RW-1:0] xs;

   int checks = 0;
   int errors = 0;

   always #(CLK_P / 2) clk = ~clk;

   mul_sub_add_unit #(.OP_W(W), .SCHED(0)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .a_i(a), .b_i(b), .c_i(c), .d_i(d), .f_i(f),
      .busy_o(busy[0]), .done_o(done[0]), .x_o(xs[0]));
   mul_sub_add_unit #(.OP_W(W), .SCHED(1)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .a_i(a), .b_i(b), .c_i(c), .d_i(d), .f_i(f),
      .busy_o(busy[1]), .done_o(done[1]), .x_o(xs[1]));
   mul_sub_add_unit #(.OP_W(W), .SCHED(2)) u2 (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .a_i(a), .b_i(b), .c_i(c), .d_i(d), .f_i(f),
      .busy_o(busy[2]), .done_o(done[2]), .x_o(xs[2]));

   function automatic longint ref_x(input logic [W-1:0] pa, pb, pc, pd, pf);
      return longint'($signed(pa)) * longint'($signed(pb))
           - longint'($signed(pc)) * longint'($signed(pd))
           + longint'($signed(pf));
   endfunction

   function automatic string lat_tag(input int i);
      if (i == 0) return "R2";
      if (i == 1) return "R3";
      return "R4";
   endfunction

   function automatic longint xval(input int i);
      return longint'($signed(xs[i]));
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_req(input logic [W-1:0] pa, pb, pc, pd, pf, input bit poke);
      longint want;
      want = ref_x(pa, pb, pc, pd, pf);
      @(negedge clk);
      a = pa; b = pb; c = pc; d = pd; f = pf;
      start = 1'b1;
      @(negedge clk);
      // after the accepting edge: scramble operands, maybe poke start while busy
      start = poke;
      a = W'($urandom); b = W'($urandom); c = W'($urandom);
      d = W'($urandom); f = W'($urandom);
      for (int i = 0; i < 3; i++) begin
         chk(busy[i] == 1'b1, "R5", longint'(busy[i]), 1);
         chk(done[i] == 1'b0, lat_tag(i), longint'(done[i]), 0);
      end
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         for (int i = 0; i < 3; i++) begin
            chk(done[i] == (k == 3 - i), lat_tag(i), longint'(done[i]), longint'(k == 3 - i));
            chk(busy[i] == (k < 3 - i), "R5", longint'(busy[i]), longint'(k < 3 - i));
            if (k == 3 - i) chk(xval(i) == want, "R1", xval(i), want);
            if (k > 3 - i)  chk(xval(i) == want, "R7", xval(i), want);
         end
      end
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         chk(done[i] == 1'b0, "R6", longint'(done[i]), 0);
         chk(xval(i) == want, "R7", xval(i), want);
         chk(busy[i] == 1'b0, "R5", longint'(busy[i]), 0);
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         chk(done[i] == 1'b0, "R8", longint'(done[i]), 0);
         chk(busy[i] == 1'b0, "R8", longint'(busy[i]), 0);
         chk(xs[i] == '0, "R8", xval(i), 0);
      end
      rst_n = 1'b1;

      // directed corners
      run_req(8'h80, 8'h80, 8'h7f, 8'h80, 8'h7f, 1'b0);  // R1 largest positive
      run_req(8'h80, 8'h7f, 8'h80, 8'h80, 8'h80, 1'b0);  // R1 most negative
      run_req(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
      run_req(8'hff, 8'hff, 8'h01, 8'h01, 8'hff, 1'b1);  // R5 poke while busy
      run_req(8'h05, 8'hfd, 8'h03, 8'h04, 8'h10, 1'b1);
      run_req(8'h7f, 8'h7f, 8'h00, 8'h55, 8'h00, 1'b0);

      // random mix
      for (int n = 0; n < 40; n++) begin
         run_req(W'($urandom), W'($urandom), W'($urandom), W'($urandom),
                 W'($urandom), bit'($urandom % 2));
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule